// File: doc/BRIEF.md
# I2C Slave Address Recognizer with Bit Mask

This block listens to an I2C bus as a slave. After each START or repeated START it collects the first byte and decides whether that byte selects this device. It shifts in seven address bits and the direction bit on rising SCL edges. It then compares the address with a programmable own-address value. Any bit position flagged in a programmable mask is left out of that compare, so one device can answer a whole family of addresses. A separate enable also lets the device accept the all-zero general-call address.

On a hit the block raises an event flag and posts a status code. It pulls SDA low for the acknowledge in the ninth clock period, and it keeps SCL low during that period until software clears the flag. The interrupt line is the flag gated by a local enable and a global enable. When the interrupt is not enabled, software polls the flag. Data bytes after the address phase are not handled here. Neither is 10-bit addressing.

The bus inputs are the resolved line levels. The two pull-low outputs go to open-drain pad drivers.

Top module: `i2c_addr_match`

## Requirements
- R1: The address byte is sampled MSB first on rising SCL edges after a START. The eighth sampled bit is the direction bit, where 0 means write and 1 means read. The upper seven bits are the address.
- R2: For each address bit whose mask bit is 1, the compare ignores that bit. For each address bit whose mask bit is 0, the received bit must equal the matching own-address bit.
- R3: While `gcall_en` is 1, address 0 is recognized only as a general call. The byte 0x00 is accepted and the byte 0x01 is ignored. While `gcall_en` is 0, address 0 is compared like any other address.
- R4: After reset `event_flag` is 0. On a recognized address the flag is set, and `status` holds 1 for own-address write, 2 for own-address read and 3 for general call. `status` reads 0 whenever the flag is clear, and a `flag_clr` pulse clears the flag.
- R5: On a hit, `sda_pull_low` is high from the first SCL fall after the eighth bit until the next SCL fall. On a miss it never rises, and the block stays idle until the next START.
- R6: `scl_pull_low` is high during the acknowledge period while the flag is set. It is low on the cycle after the edge that takes `flag_clr`.
- R7: `irq` is 1 exactly when the flag, `irq_en` and `global_irq_en` are all 1.
- R8: A STOP at any point clears the bit counter and returns the block to idle. If the device had been selected, the STOP sets the flag with status 4.
- R9: A repeated START in the middle of an address byte restarts address collection from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr | input | 7 | Own slave address |
| addr_mask | input | 7 | Per-bit compare mask, 1 = ignore that bit |
| gcall_en | input | 1 | Enables general-call recognition |
| irq_en | input | 1 | Local interrupt enable |
| global_irq_en | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | One-cycle pulse that clears the event flag |
| sda_pull_low | output | 1 | Pulls SDA low for the acknowledge |
| scl_pull_low | output | 1 | Pulls SCL low to stretch the clock |
| event_flag | output | 1 | Event pending for software |
| status | output | 3 | Bus state code while the flag is set |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-formed bus. SDA changes only while SCL is low, except for START and STOP. Each SCL and SDA level lasts longer than the synchronizer depth plus one edge register, so every edge and condition is seen exactly once. They also assume `flag_clr` is a single-cycle pulse. The stimulus meets these rules by holding every bus level for four clock cycles and by never changing SCL and SDA on the same cycle. Software clears are issued as one-cycle pulses driven on the falling clock edge.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int ADDR_BITS = 7;
  localparam int BYTE_BITS = ADDR_BITS + 1;

  typedef enum logic [2:0] {
    ST_NONE   = 3'd0,
    ST_OWN_WR = 3'd1,
    ST_OWN_RD = 3'd2,
    ST_GCALL  = 3'd3,
    ST_STOP   = 3'd4
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_HIT  = 3'd2,
    PH_ACK  = 3'd3,
    PH_SEL  = 3'd4
  } phase_e;

  // Masked equality: a set mask bit forces that position to count as equal.
  function automatic logic masked_equal(input logic [ADDR_BITS-1:0] rx,
                                        input logic [ADDR_BITS-1:0] own,
                                        input logic [ADDR_BITS-1:0] mask);
    return &(~(rx ^ own) | mask);
  endfunction

  // Sort a received byte into a status code, ST_NONE when not addressed.
  function automatic stat_e classify(input logic [BYTE_BITS-1:0] rx_byte,
                                     input logic [ADDR_BITS-1:0] own,
                                     input logic [ADDR_BITS-1:0] mask,
                                     input logic                 gc_en);
    logic [ADDR_BITS-1:0] a;
    logic                 rd;
    a  = rx_byte[BYTE_BITS-1:1];
    rd = rx_byte[0];
    if (gc_en && (a == '0))
      return rd ? ST_NONE : ST_GCALL;
    if (masked_equal(a, own, mask))
      return rd ? ST_OWN_RD : ST_OWN_WR;
    return ST_NONE;
  endfunction
endpackage

// File: rtl/i2c_am_edges.sv
module i2c_am_edges #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh[0] <= scl_i;
          sda_sh[0] <= sda_i;
          for (int k = 1; k < SYNC_STAGES; k++) begin
            scl_sh[k] <= scl_sh[k-1];
            sda_sh[k] <= sda_sh[k-1];
          end
        end
      end
      assign scl_m = scl_sh[SYNC_STAGES-1];
      assign sda_m = sda_sh[SYNC_STAGES-1];
    end else begin : g_direct
      assign scl_m = scl_i;
      assign sda_m = sda_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_m;
      sda_q <= sda_m;
    end
  end

  assign sda_s     = sda_m;
  assign scl_rise  = scl_m & ~scl_q;
  assign scl_fall  = ~scl_m & scl_q;
  assign start_det = scl_m & scl_q & sda_q & ~sda_m;
  assign stop_det  = scl_m & scl_q & ~sda_q & sda_m;
endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         restart,
  input  logic                         shift_en,
  input  logic                         bit_in,
  output logic [BYTE_W-1:0]            rx_byte,
  output logic [$clog2(BYTE_W+1)-1:0]  bit_cnt,
  output logic                         byte_done
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (restart) begin
      sh      <= '0;
      bit_cnt <= '0;
    end else if (shift_en && (bit_cnt < CNT_W'(BYTE_W))) begin
      sh      <= {sh[BYTE_W-3:0], bit_in};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign rx_byte   = {sh, bit_in};
  assign byte_done = shift_en && (bit_cnt == CNT_W'(BYTE_W - 1));

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (bit_cnt == '0)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(BYTE_W)); // R1
endmodule

// File: rtl/i2c_am_evflag.sv
module i2c_am_evflag
  import i2c_am_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_evt,
  input  stat_e set_code,
  input  logic  clr,
  input  logic  irq_en,
  input  logic  gie,
  output logic  flag,
  output stat_e status,
  output logic  irq
);
  stat_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      code_q <= ST_NONE;
    end else if (set_evt) begin
      flag   <= 1'b1;
      code_q <= set_code;
    end else if (clr) begin
      flag   <= 1'b0;
    end
  end

  assign status = flag ? code_q : ST_NONE;
  assign irq    = flag & irq_en & gie;

  AST_SET_POSTS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> (flag && (status == $past(set_code)))); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag); // R4
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [ADDR_BITS-1:0] own_addr,
  input  logic [ADDR_BITS-1:0] addr_mask,
  input  logic                 gcall_en,
  input  logic                 irq_en,
  input  logic                 global_irq_en,
  input  logic                 flag_clr,
  output logic                 sda_pull_low,
  output logic                 scl_pull_low,
  output logic                 event_flag,
  output logic [2:0]           status,
  output logic                 irq
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  // Named internal events
  logic                 sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                 restart, shift_en, byte_done, addr_hit, selected, set_evt;
  logic [BYTE_BITS-1:0] rx_byte;
  logic [CNT_W-1:0]     bit_cnt;
  stat_e                hit_code, set_code, stat_q;
  phase_e               phase, phase_nx;

  i2c_am_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign restart  = start_det | stop_det;
  assign shift_en = scl_rise && (phase == PH_ADDR);

  i2c_am_shifter #(.BYTE_W(BYTE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .restart(restart), .shift_en(shift_en),
    .bit_in(sda_s), .rx_byte(rx_byte), .bit_cnt(bit_cnt), .byte_done(byte_done)
  );

  assign hit_code = classify(rx_byte, own_addr, addr_mask, gcall_en);
  assign addr_hit = (hit_code != ST_NONE);
  assign selected = (phase == PH_HIT) || (phase == PH_ACK) || (phase == PH_SEL);

  always_comb begin
    phase_nx = phase;
    if (stop_det)       phase_nx = PH_IDLE;
    else if (start_det) phase_nx = PH_ADDR;
    else begin
      case (phase)
        PH_ADDR: if (byte_done) phase_nx = addr_hit ? PH_HIT : PH_IDLE;
        PH_HIT:  if (scl_fall)  phase_nx = PH_ACK;
        PH_ACK:  if (scl_fall)  phase_nx = PH_SEL;
        default: phase_nx = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  assign set_evt  = (byte_done && addr_hit && !restart && (phase == PH_ADDR))
                  | (stop_det && selected);
  assign set_code = stop_det ? ST_STOP : hit_code;

  i2c_am_evflag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .set_code(set_code),
    .clr(flag_clr), .irq_en(irq_en), .gie(global_irq_en),
    .flag(event_flag), .status(stat_q), .irq(irq)
  );

  assign status       = stat_q;
  assign sda_pull_low = (phase == PH_ACK);
  assign scl_pull_low = event_flag && (phase == PH_ACK);

  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> $past(scl_fall)); // R5
  AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !addr_hit && !restart) |=> (!sda_pull_low && phase == PH_IDLE)); // R5
  AST_MASK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_ADDR && !restart
     && (((rx_byte[BYTE_BITS-1:1] ^ own_addr) & ~addr_mask) == '0)
     && !(gcall_en && rx_byte[BYTE_BITS-1:1] == '0)) |=> (phase == PH_HIT)); // R2
  AST_GC_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && gcall_en && rx_byte == BYTE_BITS'(1)) |=> !sda_pull_low); // R3
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (phase == PH_IDLE && !sda_pull_low && !scl_pull_low)); // R8
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (phase == PH_ADDR && bit_cnt == '0)); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !set_evt) |=> !scl_pull_low); // R6
endmodule

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  import i2c_am_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] own = '0, mask = '0;
  logic gc = 1'b0, ie = 1'b0, gie = 1'b0, clr = 1'b0;
  logic sda_pl, scl_pl, flag, irq;
  logic [2:0] status;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_match dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(m_sda),
    .own_addr(own), .addr_mask(mask), .gcall_en(gc), .irq_en(ie),
    .global_irq_en(gie), .flag_clr(clr), .sda_pull_low(sda_pl),
    .scl_pull_low(scl_pl), .event_flag(flag), .status(status), .irq(irq)
  );

  // {own[7], mask[7], gcall_en, byte[8], expected status[3]}
  localparam logic [25:0] VEC [12] = '{
    {7'h2A, 7'h00, 1'b0, 8'h54, 3'd1},
    {7'h2A, 7'h00, 1'b0, 8'h55, 3'd2},
    {7'h2A, 7'h00, 1'b0, 8'h56, 3'd0},
    {7'h2A, 7'h01, 1'b0, 8'h56, 3'd1},
    {7'h50, 7'h0F, 1'b0, 8'hB9, 3'd2},
    {7'h50, 7'h0F, 1'b0, 8'hD8, 3'd0},
    {7'h11, 7'h00, 1'b1, 8'h00, 3'd3},
    {7'h11, 7'h00, 1'b1, 8'h01, 3'd0},
    {7'h11, 7'h00, 1'b0, 8'h00, 3'd0},
    {7'h00, 7'h00, 1'b0, 8'h00, 3'd1},
    {7'h7F, 7'h7F, 1'b0, 8'h67, 3'd2},
    {7'h40, 7'h00, 1'b0, 8'h02, 3'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; gap(Q); m_scl = 1'b1; gap(Q); m_scl = 1'b0; gap(Q);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic start_c;
    m_sda = 1'b0; gap(Q); m_scl = 1'b0; gap(Q);
  endtask

  task automatic stop_c;
    m_sda = 1'b0; gap(Q); m_scl = 1'b1; gap(Q); m_sda = 1'b1; gap(Q);
  endtask

  task automatic clr_pulse;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  // Checks after the eighth SCL fall, then ACK, release, ninth clock and STOP.
  task automatic finish_txn(input logic [2:0] exp);
    bit hit;
    hit = (exp != 3'd0);
    check(flag == hit, "R4 flag", flag, hit);
    check(status == exp, "R4 status", status, exp);
    check(sda_pl == hit, "R5 ack", sda_pl, hit);
    check(scl_pl == hit, "R6 stretch", scl_pl, hit);
    check(irq == (hit & ie & gie), "R7 irq", irq, hit & ie & gie);
    m_sda = 1'b1;
    if (hit) begin
      gap(6);
      check(scl_pl == 1'b1, "R6 held", scl_pl, 1);
      clr_pulse;
      check(scl_pl == 1'b0, "R6 release", scl_pl, 0);
      check(status == 3'd0, "R4 status cleared", status, 0);
    end
    m_scl = 1'b1; gap(Q); m_scl = 1'b0; gap(Q);
    check(sda_pl == 1'b0, "R5 ack end", sda_pl, 0);
    stop_c;
    check(flag == hit, "R8 stop flag", flag, hit);
    if (hit) begin
      check(status == 3'd4, "R8 stop status", status, 4);
      clr_pulse;
    end
    gap(Q);
  endtask

  task automatic run_txn(input logic [6:0] o, input logic [6:0] m, input logic g,
                         input logic [7:0] b, input logic [2:0] exp);
    own = o; mask = m; gc = g;
    start_c;
    byte_out(b);
    finish_txn(exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    gap(3);
    check(flag == 1'b0, "R4 reset flag", flag, 0);
    check(status == 3'd0, "R4 reset status", status, 0);
    check(sda_pl == 1'b0, "R5 reset sda", sda_pl, 0);
    check(scl_pl == 1'b0, "R6 reset scl", scl_pl, 0);
    rst_n = 1'b1;
    gap(Q);

    // Table walk: R1 R2 R3 R4 R5 R6 R8
    foreach (VEC[i])
      run_txn(VEC[i][25:19], VEC[i][18:12], VEC[i][11], VEC[i][10:3], VEC[i][2:0]);

    // R7: interrupt gating
    ie = 1'b1; gie = 1'b0;
    run_txn(7'h2A, 7'h00, 1'b0, 8'h54, 3'd1);
    gie = 1'b1;
    run_txn(7'h2A, 7'h00, 1'b0, 8'h54, 3'd1);
    ie = 1'b0;
    run_txn(7'h2A, 7'h00, 1'b0, 8'h55, 3'd2);
    gie = 1'b0;

    // R9: repeated START after three bits restarts the address
    own = 7'h2A; mask = 7'h00; gc = 1'b0;
    start_c;
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b1);
    m_sda = 1'b1; gap(Q); m_scl = 1'b1; gap(Q);
    start_c;
    byte_out(8'h55);
    check(status == 3'd2, "R9 restart status", status, 2);
    finish_txn(3'd2);

    // R8: STOP mid-address, then clocks without START stay idle
    start_c;
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
    stop_c;
    m_scl = 1'b0; gap(Q);
    byte_out(8'h54);
    check(flag == 1'b0, "R8 idle flag", flag, 0);
    check(sda_pl == 1'b0, "R8 idle ack", sda_pl, 0);
    m_scl = 1'b1; gap(Q); m_scl = 1'b0; gap(Q);
    stop_c;
    check(flag == 1'b0, "R8 unselected stop", flag, 0);
    run_txn(7'h2A, 7'h00, 1'b0, 8'h54, 3'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule